// File: doc/BRIEF.md
# Vector Multiply-Sum Accumulate Unit

This unit executes one vector instruction: it views each of two 128-bit source vectors as a pair of unsigned 64-bit elements and multiplies the elements of matching position. It adds both full 128-bit products to a 128-bit addend vector and returns the low 128 bits of that sum. Element 0 sits in bits 127:64 of a vector and element 1 sits in bits 63:0. With suitable second-source and addend values, the same operation gives a horizontal add, a horizontal subtract, or a single even or odd 64x64 product.

The block also decodes the 32-bit instruction word. It checks the fixed opcode fields and extracts four register indices, each mapped into the upper half of a 64-entry register space. It samples a vector-enable status bit as well. Operands arrive on a valid/ready handshake that is open only while the unit is idle. The multiply runs digit-serially under a four-state controller: ST_IDLE, ST_ELEM0, ST_ELEM1 and ST_DONE. The transitions are as follows.
- ST_IDLE moves to ST_ELEM0 when a legal, enabled operation is accepted.
- ST_IDLE moves to ST_DONE when an accepted operation traps.
- ST_ELEM0 moves to ST_ELEM1, and ST_ELEM1 moves to ST_DONE, each after its last digit step.
- ST_DONE moves back to ST_IDLE when the consumer takes the result.

The result, or a trap flag, is held on the output until it is taken.

Top module: `vmsa_unit`

## Requirements
- R1: For a legal, enabled operation, out_result equals (C + A0*B0 + A1*B1) mod 2^128. Element 0 of a vector is bits 127:64 and element 1 is bits 63:0. out_valid stays low in the cycle after acceptance.
- R2: Both multiplications treat their operands as unsigned 64-bit values. With every operand all-ones, each product is (2^64-1)^2.
- R3: Any carry out of bit 127 is discarded.
- R4: An instruction word is legal when (insn & 0xFC00003F) == 0x10000023. This means bits 31:26 equal 4 and bits 5:0 equal 35, and the register fields are ignored. An illegal word sets out_illegal and gives a zero result, whatever the value of vec_en.
- R5: out_dst, out_src_a, out_src_b and out_src_c equal 32 plus insn[25:21], insn[20:16], insn[15:11] and insn[10:6] respectively.
- R6: A legal word accepted with vec_en = 0 sets out_vec_unavail, clears out_illegal and gives a zero result.
- R7: in_ready is high only in ST_IDLE. It is high after reset, and it is low whenever out_valid is high.
- R8: While out_valid is high and out_ready is low, out_valid and all result outputs hold their values.
- R9: A trapping operation (R4 or R6) raises out_valid in the cycle after acceptance.
- R10: out_illegal and out_vec_unavail are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation will be taken |
| insn | input | 32 | Instruction word |
| vec_en | input | 1 | Vector-enable status bit |
| src_a | input | 128 | First multiplicand vector |
| src_b | input | 128 | Second multiplicand vector |
| src_c | input | 128 | Addend vector |
| out_valid | output | 1 | Result or trap available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Truncated multiply-sum, zero on a trap |
| out_dst | output | 6 | Target register index |
| out_src_a | output | 6 | First source register index |
| out_src_b | output | 6 | Second source register index |
| out_src_c | output | 6 | Addend register index |
| out_illegal | output | 1 | Opcode mismatch |
| out_vec_unavail | output | 1 | Vector-unavailable trap |

## Verification
If the digit counter or the element select goes wrong, a partial product is dropped, repeated or taken from the wrong lane. That error shows up in out_result at the handshake 2*ELEM_W/DIGIT_W+1 cycles after acceptance. The half-product vectors (one element zeroed) and the all-ones vectors separate the two lanes and expose lost carries. A wrong controller state shows up at once: in_ready stays open during a busy operation, a trap misses the next-cycle out_valid, or the output changes while stalled. The scoreboard compares every beat under a stalling consumer, so any drift between beats is caught on the next negative edge.

// File: rtl/vmsa_pkg.sv
package vmsa_pkg;
    localparam int INSN_W     = 32;
    localparam int FIELD_W    = 5;
    localparam int IDX_W      = FIELD_W + 1;
    localparam int NUM_FIELDS = 4;
    localparam int FIELD_TOP  = INSN_W - 7;      // LSB-numbered top bit of first field
    localparam logic [IDX_W-1:0]  IDX_BASE  = IDX_W'(32);
    localparam logic [INSN_W-1:0] OPC_MASK  = 32'hFC00003F;
    localparam logic [INSN_W-1:0] OPC_MATCH = 32'h10000023;

    // field slots in the decoded index array
    localparam int F_DST = 0;
    localparam int F_SA  = 1;
    localparam int F_SB  = 2;
    localparam int F_SC  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ELEM0 = 2'd1,
        ST_ELEM1 = 2'd2,
        ST_DONE  = 2'd3
    } vmsa_state_e;
endpackage

// File: rtl/vmsa_decode.sv
module vmsa_decode
    import vmsa_pkg::*;
(
    input  logic [INSN_W-1:0]                   insn,
    output logic                                match,
    output logic [NUM_FIELDS-1:0][IDX_W-1:0]    idx
);
    assign match = (insn & OPC_MASK) == OPC_MATCH;

    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
        localparam int HI = FIELD_TOP - FIELD_W * k;
        assign idx[k] = IDX_W'(insn[HI -: FIELD_W]) + IDX_BASE;
    end
endmodule

// File: rtl/vmsa_elem_pick.sv
module vmsa_elem_pick #(
    parameter int ELEM_W   = 64,
    parameter int NUM_ELEM = 2,
    localparam int VEC_W   = ELEM_W * NUM_ELEM,
    localparam int SEL_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [SEL_W-1:0]  sel,
    output logic [ELEM_W-1:0] elem
);
    logic [ELEM_W-1:0] lanes [NUM_ELEM];

    // element 0 occupies the most significant lane
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
        assign lanes[g] = vec[VEC_W-1-g*ELEM_W -: ELEM_W];
    end

    assign elem = lanes[sel];
endmodule

// File: rtl/vmsa_mac_step.sv
module vmsa_mac_step #(
    parameter int ELEM_W  = 64,
    parameter int DIGIT_W = 16,
    parameter int ACC_W   = 128,
    localparam int STEPS  = ELEM_W / DIGIT_W,
    localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int PW     = ELEM_W + DIGIT_W
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [ELEM_W-1:0] mcand,
    input  logic [ELEM_W-1:0] mplier,
    input  logic [CNT_W-1:0]  digit_idx,
    output logic [ACC_W-1:0]  acc_next
);
    logic [DIGIT_W-1:0] digits [STEPS];
    logic [ACC_W-1:0]   placed [STEPS];
    logic [DIGIT_W-1:0] digit;
    logic [PW-1:0]      prod;

    for (genvar g = 0; g < STEPS; g++) begin : g_digit
        assign digits[g] = mplier[g*DIGIT_W +: DIGIT_W];
    end

    assign digit = digits[digit_idx];
    assign prod  = {{DIGIT_W{1'b0}}, mcand} * {{ELEM_W{1'b0}}, digit};

    for (genvar g = 0; g < STEPS; g++) begin : g_place
        logic [ACC_W-1:0] ext;
        assign ext       = {{(ACC_W-PW){1'b0}}, prod};
        assign placed[g] = ext << (g * DIGIT_W);
    end

    // wraps modulo 2^ACC_W by width
    assign acc_next = acc + placed[digit_idx];
endmodule

// File: rtl/vmsa_unit.sv
module vmsa_unit
    import vmsa_pkg::*;
#(
    parameter int ELEM_W  = 64,
    parameter int DIGIT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [INSN_W-1:0]     insn,
    input  logic                  vec_en,
    input  logic [2*ELEM_W-1:0]   src_a,
    input  logic [2*ELEM_W-1:0]   src_b,
    input  logic [2*ELEM_W-1:0]   src_c,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [2*ELEM_W-1:0]   out_result,
    output logic [IDX_W-1:0]      out_dst,
    output logic [IDX_W-1:0]      out_src_a,
    output logic [IDX_W-1:0]      out_src_b,
    output logic [IDX_W-1:0]      out_src_c,
    output logic                  out_illegal,
    output logic                  out_vec_unavail
);
    localparam int VEC_W = 2 * ELEM_W;
    localparam int STEPS = ELEM_W / DIGIT_W;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    vmsa_state_e state_q, state_d;

    logic                             dec_match;
    logic [NUM_FIELDS-1:0][IDX_W-1:0] dec_idx;
    logic [NUM_FIELDS-1:0][IDX_W-1:0] idx_q;
    logic [VEC_W-1:0]                 a_q, b_q, acc_q, acc_nx;
    logic [CNT_W-1:0]                 cnt_q;
    logic                             ill_q, unav_q;
    logic [ELEM_W-1:0]                lane_a, lane_b;
    logic                             lane_sel;
    logic                             accept, step_last, go_compute;

    vmsa_decode u_dec (
        .insn  (insn),
        .match (dec_match),
        .idx   (dec_idx)
    );

    assign lane_sel = (state_q == ST_ELEM1);

    vmsa_elem_pick #(.ELEM_W(ELEM_W), .NUM_ELEM(2)) u_pick_a (
        .vec  (a_q),
        .sel  (lane_sel),
        .elem (lane_a)
    );

    vmsa_elem_pick #(.ELEM_W(ELEM_W), .NUM_ELEM(2)) u_pick_b (
        .vec  (b_q),
        .sel  (lane_sel),
        .elem (lane_b)
    );

    vmsa_mac_step #(.ELEM_W(ELEM_W), .DIGIT_W(DIGIT_W), .ACC_W(VEC_W)) u_mac (
        .acc       (acc_q),
        .mcand     (lane_a),
        .mplier    (lane_b),
        .digit_idx (cnt_q),
        .acc_next  (acc_nx)
    );

    assign accept     = in_valid && (state_q == ST_IDLE);
    assign go_compute = dec_match && vec_en;
    assign step_last  = (cnt_q == LAST);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)  state_d = go_compute ? ST_ELEM0 : ST_DONE;
            ST_ELEM0: if (step_last) state_d = ST_ELEM1;
            ST_ELEM1: if (step_last) state_d = ST_DONE;
            ST_DONE:  if (out_ready) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            ill_q  <= 1'b0;
            unav_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        a_q    <= src_a;
                        b_q    <= src_b;
                        acc_q  <= go_compute ? src_c : '0;
                        cnt_q  <= '0;
                        idx_q  <= dec_idx;
                        ill_q  <= !dec_match;
                        unav_q <= dec_match && !vec_en;
                    end
                end
                ST_ELEM0, ST_ELEM1: begin
                    acc_q <= acc_nx;
                    cnt_q <= step_last ? '0 : cnt_q + 1'b1;
                end
                ST_DONE: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign in_ready        = (state_q == ST_IDLE);
    assign out_valid       = (state_q == ST_DONE);
    assign out_result      = acc_q;
    assign out_dst         = idx_q[F_DST];
    assign out_src_a       = idx_q[F_SA];
    assign out_src_b       = idx_q[F_SB];
    assign out_src_c       = idx_q[F_SC];
    assign out_illegal     = ill_q;
    assign out_vec_unavail = unav_q;
endmodule

// File: rtl/vmsa_unit_chk.sv
module vmsa_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [31:0]       insn,
    input logic              vec_en,
    input logic              out_valid,
    input logic              out_ready,
    input logic [VEC_W-1:0]  out_result,
    input logic              out_illegal,
    input logic              out_vec_unavail
);
    logic legal_word, take;
    assign legal_word = (insn & 32'hFC00003F) == 32'h10000023;
    assign take       = in_valid && in_ready;

    // R7: no new operation while a result is pending
    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R8: stalled output holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result)
            && $stable(out_illegal) && $stable(out_vec_unavail));

    // R10: flags exclusive
    assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_illegal && out_vec_unavail));

    // R4: illegal word flagged next cycle with zero result
    assert_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !legal_word |=> out_valid && out_illegal && out_result == '0);

    // R6: disabled vector unit traps
    assert_unavail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take && legal_word && !vec_en |=> out_valid && out_vec_unavail
            && !out_illegal && out_result == '0);

    // R9: trap reported the cycle after acceptance
    assert_fast_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take && !(legal_word && vec_en) |=> out_valid);

    // R1: computation is multi-cycle, no result the next cycle
    assert_no_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take && legal_word && vec_en |=> !out_valid && !out_illegal && !out_vec_unavail);
endmodule

bind vmsa_unit vmsa_unit_chk #(.VEC_W(2*ELEM_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .insn            (insn),
    .vec_en          (vec_en),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_result      (out_result),
    .out_illegal     (out_illegal),
    .out_vec_unavail (out_vec_unavail)
);

// File: tb/vmsa_unit_tb.sv
`timescale 1ns/1ps
module vmsa_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  insn = '0;
    logic         vec_en = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, src_c = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_result;
    logic [5:0]   out_dst, out_src_a, out_src_b, out_src_c;
    logic         out_illegal, out_vec_unavail;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    typedef struct {
        logic [127:0] res;
        logic [5:0]   rt, ra, rb, rc;
        logic         ill, unav;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    vmsa_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .insn(insn), .vec_en(vec_en), .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .out_dst(out_dst), .out_src_a(out_src_a), .out_src_b(out_src_b),
        .out_src_c(out_src_c), .out_illegal(out_illegal), .out_vec_unavail(out_vec_unavail)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [4:0] rt, logic [4:0] ra, logic [4:0] rb, logic [4:0] rc);
        return {6'd4, rt, ra, rb, rc, 6'd35};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // driver: push the expectation, then offer the operation
    task automatic issue(logic [31:0] w, logic en, logic [127:0] a, logic [127:0] b,
                         logic [127:0] c, string tag);
        exp_t e;
        logic [255:0] wide;
        logic legal;
        legal = (w & 32'hFC00003F) == 32'h10000023;
        wide  = 256'(c) + 256'(a[127:64]) * 256'(b[127:64]) + 256'(a[63:0]) * 256'(b[63:0]);
        e.res  = (legal && en) ? wide[127:0] : '0;
        e.rt   = 6'd32 + 6'(w[25:21]);
        e.ra   = 6'd32 + 6'(w[20:16]);
        e.rb   = 6'd32 + 6'(w[15:11]);
        e.rc   = 6'd32 + 6'(w[10:6]);
        e.ill  = !legal;
        e.unav = legal && !en;
        e.tag  = tag;
        sb.push_back(e);
        while (!in_ready) @(negedge clk);
        insn = w; vec_en = en; src_a = a; src_b = b; src_c = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 busy after accept", 128'(in_ready), 128'(0));
        if (!(legal && en)) chk("R9 trap next cycle", 128'(out_valid), 128'(1));
        else                chk("R1 no early result", 128'(out_valid), 128'(0));
    endtask

    // monitor: compare every cycle the output is valid, pop on handshake
    initial begin
        int mcyc = 0;
        forever begin
            logic rdy;
            @(negedge clk);
            mcyc++;
            rdy = (mcyc % 3) != 2;
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    chk("R7 unexpected result", 128'(1), 128'(0));
                end else begin
                    chk({sb[0].tag, " result"}, out_result, sb[0].res);
                    chk("R5 indices", {out_dst, out_src_a, out_src_b, out_src_c},
                        {sb[0].rt, sb[0].ra, sb[0].rb, sb[0].rc});
                    chk("R4 illegal flag", 128'(out_illegal), 128'(sb[0].ill));
                    chk("R6 unavailable flag", 128'(out_vec_unavail), 128'(sb[0].unav));
                    chk("R10 exclusive flags", 128'(out_illegal && out_vec_unavail), 128'(0));
                    if (rdy) void'(sb.pop_front());
                end
            end
            out_ready = rdy;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] ones;
        logic [127:0] a;
        ones = '1;
        repeat (3) @(negedge clk);
        chk("R7 reset ready", 128'(in_ready), 128'(1));
        chk("R7 reset no valid", 128'(out_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        a = {64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444};
        // R1 horizontal add
        issue(mk(5'd1, 5'd2, 5'd3, 5'd4), 1'b1, a, {64'd1, 64'd1}, '0, "R1 hadd");
        // R1 horizontal difference
        issue(mk(5'd7, 5'd8, 5'd9, 5'd10), 1'b1, a, {64'd1, {64{1'b1}}}, '0, "R1 hsub");
        // R1 even and odd products
        issue(mk(5'd0, 5'd0, 5'd0, 5'd0), 1'b1, {64'hFEDC_BA98_7654_3210, 64'h0},
              rnd128(), '0, "R1 even product");
        issue(mk(5'd31, 5'd31, 5'd31, 5'd31), 1'b1, rnd128(),
              {64'h0, 64'hDEAD_BEEF_CAFE_F00D}, '0, "R1 odd product");
        // R2 unsigned full-width products, R3 wrap with all-ones
        issue(mk(5'd3, 5'd4, 5'd5, 5'd6), 1'b1, ones, ones, '0, "R2 unsigned ones");
        issue(mk(5'd3, 5'd4, 5'd5, 5'd6), 1'b1, ones, ones, ones, "R3 wrap all ones");
        issue(mk(5'd12, 5'd13, 5'd14, 5'd15), 1'b1, {64'h1, 64'h0}, {64'h1, 64'h0},
              ones, "R3 carry dropped");
        // random operands
        for (int i = 0; i < 6; i++)
            issue(mk(5'(i), 5'(i+1), 5'(i+2), 5'(i+3)), 1'b1, rnd128(), rnd128(),
                  rnd128(), "R1 random");
        // R6 disabled unit, R4 wrong primary and extended opcode
        issue(mk(5'd9, 5'd10, 5'd11, 5'd12), 1'b0, ones, ones, ones, "R6 disabled");
        issue({6'd5, 20'h0, 6'd35}, 1'b1, ones, ones, ones, "R4 bad primary");
        issue({6'd4, 20'hFFFFF, 6'd34}, 1'b1, ones, ones, ones, "R4 bad extended");
        issue({6'd5, 20'h0, 6'd35}, 1'b0, ones, ones, ones, "R4 illegal over disabled");
        // R4 register fields do not affect legality
        issue({6'd4, 20'hFFFFF, 6'd35}, 1'b1, rnd128(), rnd128(), rnd128(), "R4 fields ignored");
        issue(mk(5'd17, 5'd18, 5'd19, 5'd20), 1'b1, rnd128(), rnd128(), rnd128(),
              "R1 after trap");

        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R7 idle at end", 128'(in_ready), 128'(1));
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule